// File: doc/BRIEF.md
# Bit-Serial HDLC-Style Frame Receiver with Station Address Filter

This block is the receive side of one serial channel. It takes a bit stream, one bit per cycle in which `bit_en` is high, and looks for an opening flag (`0x7E`). It removes the zero that a transmitter inserts after every run of five ones. It then assembles octets, least significant bit first. The first octet after a flag is the station address. It is compared with a programmed value, unless the filter is turned off. A frame whose address does not match is dropped silently until the next flag.

When a frame is accepted, its address octet is placed on `byte_out` and a first-character interrupt is raised. Software then sets up a DMA engine. Each later octet of the frame raises `byte_ready`, which stays high until the DMA engine pulses `byte_taken`. While the block is in a frame it also watches for two events that raise the external-status interrupt: an abort (seven or more ones in a row) and any change on the carrier-detect input. A byte that completes while the previous one has not been taken raises the special-receive interrupt. A closing flag pulses `frame_end`.

Every interrupt source has a sticky pending bit that is cleared by writing one to its clear bit. The `irq` output is high while any pending bit is set.

Top module: `sdlc_rx`

## Requirements
- R1: While reset is active and just after it, `byte_ready`, `frame_end`, `irq` and all three `irq_pending` bits are 0.
- R2: Until the first flag, the block is in the hunt phase: bits that are not a flag produce no byte, no `byte_ready` and no pending interrupt.
- R3: Inside a frame, a 0 that follows five consecutive 1s is deleted. Octets are assembled with the first received bit as bit 0, so the values `0xFF` and `0x7E` are delivered intact.
- R4: If the first octet after a flag equals `station_addr`, `irq_pending[0]` (first character) is set and `byte_out` shows that octet. `byte_ready` is not raised for the address octet.
- R5: A frame whose address octet differs from `station_addr` raises no interrupt and delivers no octet up to the next flag. When `addr_check_en` is 0, every address is accepted.
- R6: Each later octet of an accepted frame is shown on `byte_out` with `byte_ready` high. `byte_ready` stays high until a cycle with `byte_taken` high, after which it is 0.
- R7: A flag during the data phase pulses `frame_end` for one cycle and returns the block to address matching. Consecutive flags are treated as idle fill.
- R8: Seven consecutive 1s during address matching or the data phase set `irq_pending[1]` (external status) and return the block to the hunt phase, where further octets are ignored until a flag.
- R9: A change on `carrier_in` during the data phase sets `irq_pending[1]`. A change outside a frame has no effect.
- R10: If an octet completes while `byte_ready` is high and `byte_taken` is low, `irq_pending[2]` (special receive) is set and `byte_out` takes the new octet.
- R11: Each pending bit stays set until a cycle in which the matching `irq_clear` bit is 1. `irq` is 1 exactly while any pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe: `rx_bit` is valid this cycle |
| rx_bit | input | 1 | Serial receive data |
| carrier_in | input | 1 | Carrier-detect level |
| station_addr | input | BYTE_W | Programmed station address |
| addr_check_en | input | 1 | 1: filter on address; 0: accept all |
| byte_taken | input | 1 | DMA has read `byte_out` |
| irq_clear | input | 3 | Write-one-to-clear for the pending bits |
| byte_out | output | BYTE_W | Last received octet |
| byte_ready | output | 1 | Data octet waiting for DMA |
| frame_end | output | 1 | One-cycle pulse on a closing flag |
| irq_pending | output | 3 | [0] first char, [1] external status, [2] special receive |
| irq | output | 1 | OR of the pending bits |

## Verification
The bench builds the block with its defaults, `BYTE_W` = 8 and a stuffing run of five. This makes 7 ones an abort and lets hand-built octets such as `0xFF` and `0x7E` force zero deletion. Because `bit_en` is held high for whole frames, bytes arrive every eight cycles. This leaves room for a prompt DMA take, and also for a withheld take that produces an overrun. Frames with matching, non-matching and unfiltered addresses are sent, together with aborts and carrier toggles both inside and outside a frame.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ADDR = 2'd1,
    ST_SKIP = 2'd2,
    ST_DATA = 2'd3
  } rx_state_e;

  localparam int IRQ_FIRST   = 0;
  localparam int IRQ_EXT     = 1;
  localparam int IRQ_SPECIAL = 2;
  localparam int IRQ_N       = 3;
endpackage

// File: rtl/sdlc_bit_front.sv
// Run-of-ones tracker: flag, abort and zero-deletion decode.
module sdlc_bit_front #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic data_vld,
  output logic data_bit,
  output logic flag_hit,
  output logic abort_hit
);
  localparam int RUN_MAX = STUFF_RUN + 2;
  localparam int CW      = $clog2(RUN_MAX + 1);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    run_d     = run_q;
    data_vld  = 1'b0;
    data_bit  = bit_in;
    flag_hit  = 1'b0;
    abort_hit = 1'b0;
    if (bit_en) begin
      if (bit_in) begin
        run_d     = (run_q == CW'(RUN_MAX)) ? run_q : run_q + 1'b1;
        data_vld  = (run_q < CW'(STUFF_RUN));
        abort_hit = (run_q == CW'(RUN_MAX - 1));
      end else begin
        run_d    = '0;
        flag_hit = (run_q == CW'(STUFF_RUN + 1));
        data_vld = (run_q < CW'(STUFF_RUN));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (bit_en) run_q <= run_d;
  end
endmodule

// File: rtl/sdlc_rx_ctrl.sv
// Frame state machine, octet assembly, address filter, DMA handshake.
module sdlc_rx_ctrl
  import sdlc_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_vld,
  input  logic              data_bit,
  input  logic              flag_hit,
  input  logic              abort_hit,
  input  logic              carrier_in,
  input  logic [BYTE_W-1:0] station_addr,
  input  logic              addr_check_en,
  input  logic              byte_taken,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_ready,
  output logic              frame_end,
  output logic              set_first,
  output logic              set_ext,
  output logic              set_special
);
  localparam int BCW = $clog2(BYTE_W);

  rx_state_e         state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d, sh_next, hold_q, hold_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic              ready_q, ready_d, eof_q, eof_d, carrier_q;
  logic              byte_done;

  assign sh_next   = {data_bit, sh_q[BYTE_W-1:1]};
  assign byte_done = data_vld && (bcnt_q == BCW'(BYTE_W - 1));

  always_comb begin
    state_d     = state_q;
    sh_d        = sh_q;
    bcnt_d      = bcnt_q;
    hold_d      = hold_q;
    ready_d     = ready_q && !byte_taken;
    eof_d       = 1'b0;
    set_first   = 1'b0;
    set_special = 1'b0;
    set_ext     = (state_q == ST_DATA) && (carrier_in != carrier_q);
    if (state_q == ST_HUNT) begin
      if (flag_hit) begin
        state_d = ST_ADDR;
        bcnt_d  = '0;
      end
    end else if (abort_hit) begin
      state_d = ST_HUNT;
      if (state_q != ST_SKIP) set_ext = 1'b1;
    end else if (flag_hit) begin
      state_d = ST_ADDR;
      bcnt_d  = '0;
      eof_d   = (state_q == ST_DATA);
    end else if (data_vld) begin
      sh_d   = sh_next;
      bcnt_d = byte_done ? '0 : bcnt_q + 1'b1;
      if (byte_done) begin
        if (state_q == ST_ADDR) begin
          if (!addr_check_en || sh_next == station_addr) begin
            hold_d    = sh_next;
            set_first = 1'b1;
            state_d   = ST_DATA;
          end else begin
            state_d = ST_SKIP;
          end
        end else if (state_q == ST_DATA) begin
          hold_d      = sh_next;
          set_special = ready_q && !byte_taken;
          ready_d     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HUNT;
      sh_q      <= '0;
      bcnt_q    <= '0;
      hold_q    <= '0;
      ready_q   <= 1'b0;
      eof_q     <= 1'b0;
      carrier_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      sh_q      <= sh_d;
      bcnt_q    <= bcnt_d;
      hold_q    <= hold_d;
      ready_q   <= ready_d;
      eof_q     <= eof_d;
      carrier_q <= carrier_in;
    end
  end

  assign byte_out   = hold_q;
  assign byte_ready = ready_q;
  assign frame_end  = eof_q;
endmodule

// File: rtl/sdlc_irq_regs.sv
// Sticky pending bits with write-one-to-clear.
module sdlc_irq_regs #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_in,
  input  logic [N-1:0] clr_in,
  output logic [N-1:0] pending,
  output logic         irq
);
  for (genvar k = 0; k < N; k++) begin : g_src
    logic pend_d;
    always_comb pend_d = set_in[k] | (pending[k] & ~clr_in[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending[k] <= 1'b0;
      else        pending[k] <= pend_d;
    end
  end

  assign irq = |pending;
endmodule

// File: rtl/sdlc_rx.sv
module sdlc_rx
  import sdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              carrier_in,
  input  logic [BYTE_W-1:0] station_addr,
  input  logic              addr_check_en,
  input  logic              byte_taken,
  input  logic [IRQ_N-1:0]  irq_clear,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_ready,
  output logic              frame_end,
  output logic [IRQ_N-1:0]  irq_pending,
  output logic              irq
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  logic       data_vld, data_bit, flag_hit, abort_hit;
  logic       set_first, set_ext, set_special;
  logic [IRQ_N-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  sdlc_bit_front #(.STUFF_RUN(STUFF_RUN)) u_front (
    .clk(clk), .rst_n(rst_int_n), .bit_en(bit_en), .bit_in(rx_bit),
    .data_vld(data_vld), .data_bit(data_bit),
    .flag_hit(flag_hit), .abort_hit(abort_hit)
  );

  sdlc_rx_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .data_vld(data_vld), .data_bit(data_bit),
    .flag_hit(flag_hit), .abort_hit(abort_hit),
    .carrier_in(carrier_in), .station_addr(station_addr),
    .addr_check_en(addr_check_en), .byte_taken(byte_taken),
    .byte_out(byte_out), .byte_ready(byte_ready), .frame_end(frame_end),
    .set_first(set_first), .set_ext(set_ext), .set_special(set_special)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[IRQ_FIRST]   = set_first;
    set_vec[IRQ_EXT]     = set_ext;
    set_vec[IRQ_SPECIAL] = set_special;
  end

  sdlc_irq_regs #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .set_in(set_vec), .clr_in(irq_clear),
    .pending(irq_pending), .irq(irq)
  );
endmodule

// File: rtl/sdlc_rx_checker.sv
module sdlc_rx_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic [BYTE_W-1:0] station_addr,
  input logic              addr_check_en,
  input logic              byte_taken,
  input logic [2:0]        irq_clear,
  input logic [BYTE_W-1:0] byte_out,
  input logic              byte_ready,
  input logic              frame_end,
  input logic [2:0]        irq_pending
);
  a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready && !byte_taken |=> byte_ready);

  a_r6_taken_clears: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready && byte_taken && !bit_en |=> !byte_ready);

  a_r10_overrun_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending[2]) |-> $past(byte_ready));

  a_r4_first_is_address: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending[0]) |-> (!$past(addr_check_en) || byte_out == $past(station_addr)));

  a_r7_eof_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_pending) & ~$past(irq_clear) & ~irq_pending) == 3'b000);
endmodule

bind sdlc_rx sdlc_rx_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .station_addr(station_addr),
  .addr_check_en(addr_check_en), .byte_taken(byte_taken), .irq_clear(irq_clear),
  .byte_out(byte_out), .byte_ready(byte_ready), .frame_end(frame_end),
  .irq_pending(irq_pending)
);

// File: tb/sim_sdlc_rx.sv
`timescale 1ns/1ps
module sim_sdlc_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, rx_bit = 1'b1, carrier_in = 1'b0;
  logic [7:0] station_addr = 8'hA5;
  logic       addr_check_en = 1'b1;
  logic       mon_take = 1'b0, tb_take = 1'b0, mon_clr0 = 1'b0;
  logic [2:1] tb_clr = 2'b00;
  logic [7:0] byte_out;
  logic       byte_ready, frame_end, irq;
  logic [2:0] irq_pending;

  int checks = 0, fails = 0, eof_seen = 0, tb_run = 0;
  bit auto_take = 1'b1, done = 1'b0;
  logic [7:0] expq[$];

  always #10 clk = ~clk;

  sdlc_rx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .carrier_in(carrier_in), .station_addr(station_addr),
    .addr_check_en(addr_check_en), .byte_taken(mon_take | tb_take),
    .irq_clear({tb_clr, mon_clr0}), .byte_out(byte_out),
    .byte_ready(byte_ready), .frame_end(frame_end),
    .irq_pending(irq_pending), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic raw(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bit_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_flag();
    raw(1'b0);
    for (int i = 0; i < 6; i++) raw(1'b1);
    raw(1'b0);
    tb_run = 0;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit expect_it);
    if (expect_it) expq.push_back(v);
    for (int i = 0; i < 8; i++) begin
      raw(v[i]);
      if (v[i]) tb_run++; else tb_run = 0;
      if (tb_run == 5) begin
        raw(1'b0);
        tb_run = 0;
      end
    end
  endtask

  // Monitor: pops expected octets on first-character interrupt and on byte_ready.
  initial begin
    forever begin
      @(negedge clk);
      mon_take = 1'b0;
      mon_clr0 = 1'b0;
      if (frame_end) eof_seen++;
      if (rst_n && irq_pending[0]) begin
        if (expq.size() == 0) chk(1'b0, "R5 unexpected first char", byte_out, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(byte_out == e, "R4 address octet", byte_out, e);
        end
        mon_clr0 = 1'b1;
      end
      if (rst_n && byte_ready && auto_take) begin
        if (expq.size() == 0) chk(1'b0, "R2/R5/R8 unexpected octet", byte_out, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(byte_out == e, "R3/R6 data octet", byte_out, e);
        end
        mon_take = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    chk(byte_ready == 0 && irq == 0 && irq_pending == 0 && frame_end == 0,
        "R1 in reset", {byte_ready, irq, irq_pending}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(byte_ready == 0 && irq == 0 && irq_pending == 0, "R1 after reset",
        {byte_ready, irq, irq_pending}, 0);

    // R2: octets without any flag are ignored
    send_byte(8'hA5, 0); send_byte(8'h3C, 0);
    idle(4);
    chk(irq_pending == 0 && byte_ready == 0, "R2 hunt ignores data", irq_pending, 0);

    // R3/R4/R6/R7: matching frame with stuffing-heavy octets, idle flags first
    e0 = eof_seen;
    send_flag(); send_flag(); send_flag();
    send_byte(8'hA5, 1); send_byte(8'h3C, 1); send_byte(8'hFF, 1); send_byte(8'h7E, 1);
    send_flag();
    idle(4);
    chk(expq.size() == 0, "R3 all octets delivered", expq.size(), 0);
    chk(eof_seen == e0 + 1, "R7 frame_end pulse count", eof_seen - e0, 1);
    chk(byte_ready == 0, "R6 ready cleared by take", byte_ready, 0);

    // R7: back-to-back frame after shared flag still matched
    send_byte(8'hA5, 1); send_byte(8'h01, 1); send_flag(); send_flag();
    idle(4);
    chk(expq.size() == 0, "R7 second frame after closing flag", expq.size(), 0);

    // R5: non-matching address discarded
    send_flag(); send_byte(8'h11, 0); send_byte(8'h22, 0); send_byte(8'h33, 0); send_flag();
    idle(4);
    chk(irq_pending == 0 && byte_ready == 0, "R5 mismatch ignored", irq_pending, 0);

    // R5: filter off accepts any address
    addr_check_en = 1'b0;
    send_flag(); send_byte(8'h11, 1); send_byte(8'h44, 1); send_flag();
    idle(4);
    chk(expq.size() == 0, "R5 filter off accepts", expq.size(), 0);
    addr_check_en = 1'b1;

    // R8: abort inside frame
    send_flag(); send_byte(8'hA5, 1); send_byte(8'h3C, 1);
    for (int i = 0; i < 8; i++) raw(1'b1);
    idle(3);
    chk(irq_pending[1] == 1 && irq == 1, "R8 abort sets ext status", irq_pending, 3'b010);
    raw(1'b0); tb_run = 0;
    send_byte(8'h55, 0); send_byte(8'h0F, 0);
    idle(4);
    chk(byte_ready == 0 && irq_pending[0] == 0, "R8 hunt after abort", irq_pending, 3'b010);
    @(negedge clk); tb_clr = 2'b01;
    @(negedge clk); tb_clr = 2'b00;
    chk(irq_pending == 0 && irq == 0, "R11 clear ext status", {irq, irq_pending}, 0);

    // R9: carrier change inside and outside a frame
    send_flag(); send_byte(8'hA5, 1);
    idle(3);
    carrier_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq_pending[1] == 1, "R9 carrier change in frame", irq_pending, 3'b010);
    send_flag();
    idle(2);
    tb_clr = 2'b01; @(negedge clk); tb_clr = 2'b00;
    carrier_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq_pending == 0, "R9 carrier change outside frame", irq_pending, 0);

    // R10: overrun when DMA withholds take
    auto_take = 1'b0;
    send_flag(); send_byte(8'hA5, 1); send_byte(8'h01, 0); send_byte(8'h02, 0); send_flag();
    idle(3);
    chk(irq_pending[2] == 1, "R10 overrun pending", irq_pending, 3'b100);
    chk(byte_out == 8'h02 && byte_ready == 1, "R10 newest octet held", byte_out, 8'h02);
    @(negedge clk); tb_take = 1'b1;
    @(negedge clk); tb_take = 1'b0;
    chk(byte_ready == 0, "R6 manual take clears ready", byte_ready, 0);
    chk(irq_pending[2] == 1, "R11 pending sticky", irq_pending, 3'b100);
    tb_clr = 2'b10; @(negedge clk); tb_clr = 2'b00;
    chk(irq_pending == 0 && irq == 0, "R11 clear special", {irq, irq_pending}, 0);
    auto_take = 1'b1;

    idle(4);
    chk(expq.size() == 0, "R4 queue drained", expq.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule